// File: doc/BRIEF.md
# Alternating-Pattern Per-Line Ones Counter

This block gathers per-line statistics during a fixed-pattern read calibration. In that read every data line should toggle 0,1,0,1 from word to word. The read sequencer delivers a run of 8-word bursts as a stream of 16-bit words, each qualified by a valid strobe. The block throws away the leading burst and the trailing bursts. Over the 64 words in the middle it counts, for each data line on its own, how many ones landed in even word positions and how many landed in odd word positions. Each line therefore ends up with two counts between 0 and 32. A count of 0 or 32 is a solid reading. A count near 16 means the line sampled close to a strobe edge, and software uses that value to place the alignment edge.

The controller has six states. IDLE waits for a start. HEAD skips the first burst. COUNT accumulates the 64 used words. TAIL skips the remaining two bursts. FIN lasts one cycle and raises the done pulse. ERR holds the error flag. A start moves the controller from any state into HEAD. HEAD goes to COUNT after its eighth word. COUNT goes to TAIL after word position 71. TAIL goes to FIN after word position 87. FIN returns to IDLE. An end-of-read strobe seen in HEAD, COUNT or TAIL sends the controller to ERR, where it stays until the next start.

Top module: `fpc_ones_stats`

## Requirements
- R1: A one-cycle start_i clears all 32 counts to 0 in the following cycle and begins a new measurement. This holds in any state, including in the middle of a run.
- R2: Accepted word positions 0 to 7 (the first burst) and 72 to 87 (the last two bursts) never change any count.
- R3: For each accepted word at position 8 to 71, bit k of the word adds one to lane k's even count when the position is even, and to its odd count when the position is odd. Lane k's counts appear at bits [6k+5:6k] of even_ones_o and odd_ones_o.
- R4: Each count stays in the range 0 to 32. A stream of all-ones words gives 32 in every field. Words whose lines toggle every second position give 16 in every field.
- R5: A word is accepted only in a cycle where wd_valid_i is high. Idle cycles between words do not change the result.
- R6: done_o is high for exactly one cycle. That cycle is the one after the edge that accepts the word at position 87.
- R7: After word position 71 the counts hold their values until the next start. Words presented after done_o are ignored.
- R8: If rd_end_i is high before the word at position 87 has been accepted, err_o rises and stays high until the next start, and done_o is not raised. done_o and err_o are never high together.
- R9: After reset every count is 0 and done_o and err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Clears the counts and begins a measurement |
| rd_end_i | input | 1 | Strobe from the read sequencer marking the end of the read |
| wd_valid_i | input | 1 | Qualifies wd_data_i |
| wd_data_i | input | 16 | Read data word; bit k belongs to data line k |
| even_ones_o | output | 96 | Per-line ones count over even word positions, 6 bits per line |
| odd_ones_o | output | 96 | Per-line ones count over odd word positions, 6 bits per line |
| done_o | output | 1 | One-cycle pulse when the measurement is complete |
| err_o | output | 1 | Error flag: the read ended early |

## Verification
The assertions take for granted that start_i is a single-cycle pulse and that rd_end_i is not raised together with a word that completes the read. They also rely on the count bound, which holds only because the word index caps COUNT at 64 accepted words. The stimulus follows these rules. Every start is a one-cycle pulse. The end strobe is driven only after the last word of a short read. Idle cycles are placed only between valid words, and extra words are sent only after done_o has been observed.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_COUNT,
        ST_TAIL,
        ST_FIN,
        ST_ERR
    } fpc_state_e;
endpackage

// File: rtl/fpc_word_index.sv
module fpc_word_index #(
    parameter int IW   = 7,
    parameter int LAST = 87
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          adv_i,
    output logic [IW-1:0] idx_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_o <= '0;
        end else if (clr_i) begin
            idx_o <= '0;
        end else if (adv_i) begin
            idx_o <= (int'(idx_o) == LAST) ? '0 : idx_o + 1'b1;
        end
    end

    // R2: the position counter never runs past the last word of the read
    assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(idx_o) <= LAST);
endmodule

// File: rtl/fpc_lane_pair.sv
module fpc_lane_pair #(
    parameter int CW   = 6,
    parameter int MAXC = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          acc_i,
    input  logic          odd_i,
    input  logic          bit_i,
    output logic [CW-1:0] even_o,
    output logic [CW-1:0] odd_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            even_o <= '0;
            odd_o  <= '0;
        end else if (clr_i) begin
            even_o <= '0;
            odd_o  <= '0;
        end else if (acc_i && bit_i) begin
            if (odd_i) odd_o  <= odd_o + 1'b1;
            else       even_o <= even_o + 1'b1;
        end
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(even_o) <= MAXC) && (int'(odd_o) <= MAXC));
endmodule

// File: rtl/fpc_ones_stats.sv
module fpc_ones_stats
    import fpc_pkg::*;
#(
    parameter  int DW          = 16,
    parameter  int BURST_LEN   = 8,
    parameter  int NUM_BURSTS  = 11,
    parameter  int HEAD_BURSTS = 1,
    parameter  int USED_BURSTS = 8,
    localparam int USED_WORDS  = USED_BURSTS * BURST_LEN,
    localparam int MAXC        = USED_WORDS / 2,
    localparam int CW          = $clog2(MAXC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             rd_end_i,
    input  logic             wd_valid_i,
    input  logic [DW-1:0]    wd_data_i,
    output logic [DW*CW-1:0] even_ones_o,
    output logic [DW*CW-1:0] odd_ones_o,
    output logic             done_o,
    output logic             err_o
);
    localparam int TOTAL_WORDS = NUM_BURSTS * BURST_LEN;
    localparam int FIRST_USED  = HEAD_BURSTS * BURST_LEN;
    localparam int LAST_USED   = FIRST_USED + USED_WORDS - 1;
    localparam int IW          = $clog2(TOTAL_WORDS);

    fpc_state_e    state_q, state_d;
    logic [IW-1:0] idx;
    logic          in_run, adv, acc;

    assign in_run = (state_q == ST_HEAD) || (state_q == ST_COUNT) || (state_q == ST_TAIL);
    assign adv    = wd_valid_i && in_run && !start_i;
    assign acc    = wd_valid_i && (state_q == ST_COUNT) && !start_i;

    fpc_word_index #(.IW(IW), .LAST(TOTAL_WORDS - 1)) u_index (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (start_i),
        .adv_i (adv),
        .idx_o (idx)
    );

    for (genvar g = 0; g < DW; g++) begin : g_lane
        fpc_lane_pair #(.CW(CW), .MAXC(MAXC)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (start_i),
            .acc_i  (acc),
            .odd_i  (idx[0]),
            .bit_i  (wd_data_i[g]),
            .even_o (even_ones_o[g*CW +: CW]),
            .odd_o  (odd_ones_o[g*CW +: CW])
        );
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = (FIRST_USED == 0) ? ST_COUNT : ST_HEAD;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_HEAD: begin
                    if (wd_valid_i && int'(idx) == FIRST_USED - 1) state_d = ST_COUNT;
                    else if (rd_end_i)                              state_d = ST_ERR;
                end
                ST_COUNT: begin
                    if (wd_valid_i && int'(idx) == LAST_USED)
                        state_d = (LAST_USED == TOTAL_WORDS - 1) ? ST_FIN : ST_TAIL;
                    else if (rd_end_i)
                        state_d = ST_ERR;
                end
                ST_TAIL: begin
                    if (wd_valid_i && int'(idx) == TOTAL_WORDS - 1) state_d = ST_FIN;
                    else if (rd_end_i)                               state_d = ST_ERR;
                end
                ST_FIN:  state_d = ST_IDLE;
                ST_ERR:  state_d = ST_ERR;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            done_o <= (state_d == ST_FIN);
            err_o  <= (state_d == ST_ERR);
        end
    end

    assert_clear_on_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (even_ones_o == '0) && (odd_ones_o == '0));

    assert_hold_outside_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_COUNT) && !start_i |=> $stable(even_ones_o) && $stable(odd_ones_o));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o && !start_i |=> err_o);
endmodule

// File: tb/fpc_ones_stats_bench.sv
module fpc_ones_stats_bench;
    localparam int DW = 16, CW = 6, TOTAL = 88, FIRST = 8, LAST = 71;

    typedef struct packed {
        logic             err;
        logic [DW*CW-1:0] ev;
        logic [DW*CW-1:0] od;
    } exp_t;

    logic clk = 0, rst_n = 0, start = 0, rd_end = 0, valid = 0;
    logic [DW-1:0]    data = '0;
    logic [DW*CW-1:0] even_ones, odd_ones;
    logic done, err;

    exp_t sbq[$];
    exp_t last_exp;
    int total = 0, bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    fpc_ones_stats u_fpc_ones_stats (
        .clk(clk), .rst_n(rst_n), .start_i(start), .rd_end_i(rd_end),
        .wd_valid_i(valid), .wd_data_i(data),
        .even_ones_o(even_ones), .odd_ones_o(odd_ones),
        .done_o(done), .err_o(err)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] gen(input int mode, input int i);
        case (mode)
            0: return (i % 2 == 1) ? 16'hFFFF : 16'h0000;
            1: return 16'hFFFF;
            2: return 16'h0000;
            3: return (i % 2 == 1) ? 16'h0000 : 16'hFFFF;
            4: return 16'(i * 40503) ^ 16'(i << 5) ^ 16'h5A3C;
            5: return (i < FIRST || i > LAST) ? 16'hFFFF : ((i % 2 == 1) ? 16'hFFFF : 16'h0000);
            6: return ((i >> 1) % 2 == 1) ? 16'hFFFF : 16'h0000;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic exp_t model(input int mode, input bit e);
        exp_t x;
        x.err = e;
        x.ev  = '0;
        x.od  = '0;
        for (int i = FIRST; i <= LAST; i++) begin
            logic [DW-1:0] w;
            w = gen(mode, i);
            for (int k = 0; k < DW; k++) begin
                if (w[k]) begin
                    if (i % 2 == 1) x.od[k*CW +: CW] = x.od[k*CW +: CW] + 1'b1;
                    else            x.ev[k*CW +: CW] = x.ev[k*CW +: CW] + 1'b1;
                end
            end
        end
        return x;
    endfunction

    task automatic send_words(input int mode, input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            valid = 1;
            data  = gen(mode, i);
            @(negedge clk);
            valid = 0;
            if (gaps && (i % 3 == 0)) repeat (2) @(negedge clk);
        end
    endtask

    // driver: pushes the expected result, then drives a full or short read
    task automatic measure(input int mode, input int n, input bit gaps);
        exp_t x;
        x = model(mode, n < TOTAL);
        sbq.push_back(x);
        last_exp = x;
        start = 1;
        @(negedge clk);
        start = 0;
        send_words(mode, n, gaps);
        if (n < TOTAL) begin
            rd_end = 1;
            @(negedge clk);
            rd_end = 0;
        end
        while (sbq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // monitor: pops expected items as results appear
    bit prev_done = 0, prev_err = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                chk(!prev_done, "R6 done width", 128'(prev_done), 128'(0));
                if (sbq.size() == 0) begin
                    chk(0, "R6 unexpected done", 128'(1), 128'(0));
                end else begin
                    exp_t x;
                    x = sbq.pop_front();
                    chk(!x.err, "R8 done instead of err", 128'(1), 128'(x.err));
                    chk(even_ones == x.ev, "R3 even counts", 128'(even_ones), 128'(x.ev));
                    chk(odd_ones == x.od, "R3 odd counts", 128'(odd_ones), 128'(x.od));
                end
            end
            if (err && !prev_err) begin
                if (sbq.size() == 0) begin
                    chk(0, "R8 unexpected err", 128'(1), 128'(0));
                end else begin
                    exp_t x;
                    x = sbq.pop_front();
                    chk(x.err, "R8 err raised", 128'(1), 128'(x.err));
                end
            end
            prev_done = done;
            prev_err  = err;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9 reset state
        chk(even_ones == '0 && odd_ones == '0, "R9 counts after reset", 128'(even_ones), 128'(0));
        chk(!done && !err, "R9 flags after reset", 128'({done, err}), 128'(0));

        measure(0, TOTAL, 0);          // R3 ideal pattern
        measure(1, TOTAL, 0);          // R4 all ones -> 32
        measure(2, TOTAL, 0);          // R4 all zeros
        measure(3, TOTAL, 1);          // R3 inverted, R5 gaps
        measure(4, TOTAL, 1);          // R3 pseudo-random, R5
        measure(5, TOTAL, 0);          // R2 ones in skipped bursts
        measure(6, TOTAL, 0);          // R4 midpoint 16

        // R7: extra words after done are ignored
        send_words(1, 6, 0);
        repeat (2) @(negedge clk);
        chk(even_ones == last_exp.ev, "R7 even hold", 128'(even_ones), 128'(last_exp.ev));
        chk(odd_ones == last_exp.od, "R7 odd hold", 128'(odd_ones), 128'(last_exp.od));

        // R8: read ends in the middle of the window, then in the tail
        measure(1, 40, 0);
        repeat (5) @(negedge clk);
        chk(err, "R8 err sticky", 128'(err), 128'(1));
        measure(0, 80, 0);

        // R1: start clears err and counts; restart in the middle of a run
        start = 1;
        @(negedge clk);
        start = 0;
        chk(!err, "R1 start clears err", 128'(err), 128'(0));
        chk(even_ones == '0 && odd_ones == '0, "R1 counts cleared", 128'(even_ones), 128'(0));
        send_words(1, 30, 0);
        measure(0, TOTAL, 0);          // R1 restart yields only the new run

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule